// File: doc/BRIEF.md
# BCD Hundredths Stopwatch Counter

This block counts elapsed time in hundredths of a second as two BCD digits, tenths and hundredths. The counting side runs on its own stopwatch clock and advances once per tick, where a tick is a one-cycle enable at 100 Hz. A small control register on the bus clock holds a run bit and a clear bit. Software writes the run bit to start, stop or resume counting. It writes the clear bit to zero the count. Both requests cross into the counting domain through a two-flop synchronizer, so they take effect in step with the stopwatch clock and not at the moment of the bus write.

The count is visible at all times as one byte. It comes straight from the counting registers, with no holding copy. A bus reader that samples it while counting is running should read it twice and keep the value only when both reads agree. When the count wraps from 0x99 back to 0x00, the block raises a one-cycle carry that a seconds counter can use.

Top module: `stopwatchBcd`

## Requirements
- R1: After reset the count reads 0x00, the control readback reads 0 and the carry is low. The count is presented as countRd[7:4] = tenths digit and countRd[3:0] = hundredths digit, each BCD (0 to 9).
- R2: While running, each swTick raises the hundredths digit by one.
- R3: When the hundredths digit is 9, a tick sets it to 0 and raises the tenths digit by one (for example 0x09 becomes 0x10).
- R4: A tick at 0x99 while running gives 0x00 and drives carry1Hz high for exactly one swClk cycle, in the same cycle in which the count first shows 0x00.
- R5: Control bit 0 is the run bit. It reads back on ctrlRdata[0] as the value last written.
- R6: Clearing the run bit stops counting and the count is held. Setting the run bit again resumes counting from the held value.
- R7: Run requests pass through a two-stage synchronizer into the swClk domain. A tick in the first swClk cycle after a stop write still increments the count once.
- R8: Writing 1 to control bit 1 sets the count to 0x00. Writing 0 to that bit leaves the count unchanged. ctrlRdata[1] always reads 0.
- R9: A clear while running does not stop counting. Later ticks count up from 0x00.
- R10: A clear while idle leaves the count at 0x00, and later ticks do not change it.
- R11: If a clear and a running tick act in the same swClk cycle, the clear wins. The count becomes 0x00 and carry1Hz stays low, even at 0x99.
- R12: Ticks that arrive while the counter is idle change neither the count nor carry1Hz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register interface clock |
| busRstN | input | 1 | Asynchronous active-low reset, bus domain |
| ctrlWe | input | 1 | Write strobe for the control register |
| ctrlWdata | input | 2 | Write data: bit 0 run, bit 1 clear |
| ctrlRdata | output | 2 | Readback: bit 0 run, bit 1 always 0 |
| swClk | input | 1 | Stopwatch counting clock |
| swRstN | input | 1 | Asynchronous active-low reset, stopwatch domain |
| swTick | input | 1 | 100 Hz one-cycle count enable, swClk domain |
| countRd | output | 8 | Tenths digit in [7:4], hundredths digit in [3:0] |
| carry1Hz | output | 1 | One-cycle pulse on the wrap from 0x99 to 0x00 |

## Verification
The clear request and a running tick can reach the digit registers on the same swClk edge. The bench sets this up by timing a tick so that it is sampled on the exact edge where the synchronized clear strobe is live. It first counts up to 0x99, so the collision also competes with the wrap carry. The monitor then expects 0x00 with carry1Hz low. A second race, between a stop write and a tick still inside the synchronizer delay, is judged by expecting one extra increment.

// File: rtl/swPkg.sv
package swPkg;

  // Control register bit positions (software contract)
  localparam int RUN_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int CTRL_W  = 2;

  // Strobes from control to datapath, swClk domain
  typedef struct packed {
    logic incr;   // advance the count by one
    logic clear;  // force the count to zero
  } swStrobeT;

endpackage

// File: rtl/swSync.sv
module swSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/swCtrl.sv
module swCtrl
  import swPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              swClk,
  input  logic              swRstN,
  input  logic              swTick,
  output swStrobeT          strobes
);

  // Bus domain: run level and a toggle that records each clear request
  logic runReg;
  logic clrToggle;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      runReg    <= 1'b0;
      clrToggle <= 1'b0;
    end else if (ctrlWe) begin
      runReg <= ctrlWdata[RUN_BIT];
      if (ctrlWdata[CLR_BIT]) clrToggle <= ~clrToggle;
    end
  end

  always_comb begin
    ctrlRdata          = '0;
    ctrlRdata[RUN_BIT] = runReg;
  end

  // Crossing into the stopwatch domain
  logic [1:0] syncQ;
  logic       runSync;
  logic       togSync;
  logic       togSeen;

  swSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) uSync (
    .clk (swClk),
    .rstN(swRstN),
    .d   ({clrToggle, runReg}),
    .q   (syncQ)
  );

  assign runSync = syncQ[0];
  assign togSync = syncQ[1];

  always_ff @(posedge swClk or negedge swRstN) begin
    if (!swRstN) togSeen <= 1'b0;
    else         togSeen <= togSync;
  end

  always_comb begin
    strobes.incr  = swTick & runSync;
    strobes.clear = togSync ^ togSeen;
  end

  // R5: the run bit reads back the value written on the previous bus edge
  a_r5_run_readback: assert property (@(posedge busClk) disable iff (!busRstN)
    ctrlWe |=> ctrlRdata[RUN_BIT] == $past(ctrlWdata[RUN_BIT]));

  // R5: without a write the run readback holds
  a_r5_run_stable: assert property (@(posedge busClk) disable iff (!busRstN)
    !ctrlWe |=> $stable(ctrlRdata[RUN_BIT]));

  // R12: no advance is requested without a tick
  a_r12_incr_needs_tick: assert property (@(posedge swClk) disable iff (!swRstN)
    !swTick |-> !strobes.incr);

endmodule

// File: rtl/swDatapath.sv
module swDatapath
  import swPkg::*;
#(
  parameter int DIGITS  = 2,
  parameter int DIGIT_W = 4,
  localparam int CNT_W  = DIGITS * DIGIT_W
) (
  input  logic             swClk,
  input  logic             swRstN,
  input  swStrobeT         strobes,
  output logic [CNT_W-1:0] count,
  output logic             carry1Hz
);

  localparam logic [DIGIT_W-1:0] DIGIT_MAX = DIGIT_W'(9);

  // ripple[g] is the advance request reaching digit g
  logic [DIGITS:0] ripple;
  assign ripple[0] = strobes.incr;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [DIGIT_W-1:0] digitQ;
    logic               atMax;

    assign atMax       = (digitQ == DIGIT_MAX);
    assign ripple[g+1] = ripple[g] & atMax;

    always_ff @(posedge swClk or negedge swRstN) begin
      if (!swRstN)            digitQ <= '0;
      else if (strobes.clear) digitQ <= '0;
      else if (ripple[g])     digitQ <= atMax ? '0 : digitQ + 1'b1;
    end

    assign count[g*DIGIT_W +: DIGIT_W] = digitQ;

    // R1: each digit stays a legal BCD value
    a_r1_digit_bcd: assert property (@(posedge swClk) disable iff (!swRstN)
      digitQ <= DIGIT_MAX);
  end

  always_ff @(posedge swClk or negedge swRstN) begin
    if (!swRstN) carry1Hz <= 1'b0;
    else         carry1Hz <= ~strobes.clear & ripple[DIGITS];
  end

  // R8: a clear strobe zeroes the count on the next edge
  a_r8_clear_zeroes: assert property (@(posedge swClk) disable iff (!swRstN)
    strobes.clear |=> count == '0);

  // R12: with no strobe the count holds
  a_r12_hold: assert property (@(posedge swClk) disable iff (!swRstN)
    (!strobes.incr && !strobes.clear) |=> $stable(count));

  // R2: an advance without clear always changes the count
  a_r2_advance_moves: assert property (@(posedge swClk) disable iff (!swRstN)
    (strobes.incr && !strobes.clear) |=> count != $past(count));

  // R4: the carry pulse coincides with a zero count and lasts one cycle
  a_r4_carry_at_zero: assert property (@(posedge swClk) disable iff (!swRstN)
    carry1Hz |-> count == '0);

  a_r4_carry_single: assert property (@(posedge swClk) disable iff (!swRstN)
    carry1Hz |=> !carry1Hz);

  // R11: a clear never produces a carry
  a_r11_clear_no_carry: assert property (@(posedge swClk) disable iff (!swRstN)
    strobes.clear |=> !carry1Hz);

endmodule

// File: rtl/stopwatchBcd.sv
module stopwatchBcd
  import swPkg::*;
#(
  parameter int DIGITS      = 2,
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = DIGITS * DIGIT_W
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              swClk,
  input  logic              swRstN,
  input  logic              swTick,
  output logic [CNT_W-1:0]  countRd,
  output logic              carry1Hz
);

  swStrobeT strobes;

  swCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .busClk   (busClk),
    .busRstN  (busRstN),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata),
    .swClk    (swClk),
    .swRstN   (swRstN),
    .swTick   (swTick),
    .strobes  (strobes)
  );

  swDatapath #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) uData (
    .swClk   (swClk),
    .swRstN  (swRstN),
    .strobes (strobes),
    .count   (countRd),
    .carry1Hz(carry1Hz)
  );

endmodule

// File: tb/sim_stopwatchBcd.sv
module sim_stopwatchBcd;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWe = 1'b0;
  logic [1:0] ctrlWdata = '0;
  logic [1:0] ctrlRdata;
  logic       swTick = 1'b0;
  logic [7:0] countRd;
  logic       carry1Hz;

  always #2 clk = ~clk;   // 250 MHz

  stopwatchBcd u0 (
    .busClk   (clk),
    .busRstN  (rstN),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata),
    .swClk    (clk),
    .swRstN   (rstN),
    .swTick   (swTick),
    .countRd  (countRd),
    .carry1Hz (carry1Hz)
  );

  typedef struct {
    logic [7:0] cnt;
    logic       cry;
    string      tag;
  } expItemT;

  expItemT expQ[$];
  int  checksRun  = 0;
  int  checksFail = 0;
  int  model      = 0;     // decimal model of the count
  bit  modelRun   = 0;
  bit  finished   = 0;
  logic tickSeen  = 1'b0;

  function automatic logic [7:0] toBcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checksRun++;
    if (act !== exp) begin
      checksFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checksRun, checksFail);
      $finish;
    end
  endtask

  // Monitor: after each tick edge, pop the expected item and compare
  always @(posedge clk) tickSeen <= swTick;

  always @(negedge clk) begin
    if (tickSeen) begin
      if (expQ.size() == 0) begin
        check("scoreboard underflow", 8'h01, 8'h00);
      end else begin
        expItemT it;
        it = expQ.pop_front();
        check({it.tag, " count"}, countRd, it.cnt);
        check({it.tag, " carry"}, {7'd0, carry1Hz}, {7'd0, it.cry});
      end
    end
  end

  // Driver tasks: each starts and ends at a falling edge
  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(bit run, bit clr);
    ctrlWe    = 1'b1;
    ctrlWdata = {clr, run};
    @(negedge clk);
    ctrlWe    = 1'b0;
    ctrlWdata = '0;
  endtask

  task automatic tickExpect(string tag, logic [7:0] cnt, logic cry);
    expItemT it;
    it.cnt = cnt;
    it.cry = cry;
    it.tag = tag;
    expQ.push_back(it);
    swTick = 1'b1;
    @(negedge clk);
    swTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic doTick(string tag);
    logic cry;
    cry = 1'b0;
    if (modelRun) begin
      cry   = (model == 99);
      model = (model + 1) % 100;
    end
    tickExpect(tag, toBcd(model), cry);
  endtask

  initial begin
    #(200000 * 4);
    checksRun++;
    checksFail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 reset count", countRd, 8'h00);
    check("R1 reset ctrl", {6'd0, ctrlRdata}, 8'h00);
    check("R1 reset carry", {7'd0, carry1Hz}, 8'h00);

    // R12: ticks while idle
    for (int i = 0; i < 3; i++) doTick("R12 idle tick");

    // R5: start counting
    busWrite(1, 0);
    check("R5 run readback set", {6'd0, ctrlRdata}, 8'h01);
    modelRun = 1;
    waitCyc(3);

    // R2 / R3: count up past 0x09
    for (int i = 0; i < 12; i++) doTick(model == 9 ? "R3 digit carry" : "R2 advance");

    // R7: stop, with a tick inside the synchronizer delay
    busWrite(0, 0);
    model = model + 1;
    tickExpect("R7 stop overshoot", toBcd(model), 1'b0);
    modelRun = 0;
    waitCyc(3);
    check("R5 run readback clear", {6'd0, ctrlRdata}, 8'h00);
    for (int i = 0; i < 3; i++) doTick("R6 held while stopped");

    // R6: resume from held value
    busWrite(1, 0);
    modelRun = 1;
    waitCyc(3);
    doTick("R6 resume");

    // R8 / R9: clear while running
    busWrite(1, 1);
    check("R8 clear reads zero", {6'd0, ctrlRdata}, 8'h01);
    waitCyc(4);
    model = 0;
    check("R8 clear zeroes", countRd, 8'h00);
    doTick("R9 continue after clear");

    // R8: writing 0 to the clear bit has no effect
    busWrite(1, 0);
    waitCyc(4);
    check("R8 clear zero ignored", countRd, toBcd(model));

    // R4: wrap at 0x99 with carry
    while (model != 99) doTick("R2 run to wrap");
    doTick("R4 wrap carry");
    check("R4 carry single cycle", {7'd0, carry1Hz}, 8'h00);
    doTick("R4 after wrap");

    // R11: clear and tick on the same edge at 0x99
    while (model != 99) doTick("R2 run to collide");
    busWrite(1, 1);
    waitCyc(2);
    model = 0;
    tickExpect("R11 clear beats tick", 8'h00, 1'b0);
    waitCyc(2);
    doTick("R9 count from zero after collision");

    // R10: clear while idle
    busWrite(0, 0);
    modelRun = 0;
    waitCyc(4);
    busWrite(0, 1);
    waitCyc(4);
    model = 0;
    check("R10 idle clear", countRd, 8'h00);
    for (int i = 0; i < 3; i++) doTick("R10 idle holds zero");

    waitCyc(4);
    check("scoreboard drained", 8'(expQ.size()), 8'h00);
    report();
  end

endmodule